// File: doc/BRIEF.md
# Scratchpad Memory Transaction Sequencer

This block turns a single start request into a complete memory transaction against a serial slave device. The slave holds a staging scratchpad in front of a battery-backed memory. The sequencer drives a byte-level engine underneath it. That engine handles the wire timing, and its operations are a line reset, writing one byte, reading one byte, and sampling the data line. A read transaction fetches a run of bytes from a 16-bit start address and streams them out. A write transaction first stages the bytes held in a small local buffer into the scratchpad. It then reads the scratchpad back and compares every byte. Only when all bytes match does it commit them with a copy command. That copy command echoes the authorisation bytes that the slave returned. Finally the sequencer polls the data line until the slave reports that it is no longer busy.

When the block comes out of reset, it runs one write transaction on its own. That write stores the oscillator-enable value in the slave's control register. Host software and any conversion between calendar time and the slave's seconds counter happen outside this block.

Top module: `scr_seq_top`

## Requirements
- R1: Engine operation codes on `eng_kind` are 0 line reset, 1 write `eng_wbyte`, 2 read a byte into `eng_rbyte`, and 3 sample the line level into `eng_rbyte[0]`. A read transaction issues, in this order: a reset, the byte 0xF0, the address low byte, the address high byte, then `len` reads. Each byte that is read appears once on `rd_data` with `rd_valid` high, in address order.
- R2: A write transaction issues, in this order: a reset, the byte 0x0F, the address low byte, the address high byte, then the buffer bytes in the order they were loaded through `wr_load`. The load position returns to zero on every accepted start.
- R3: After the staging bytes, a write issues a reset and the byte 0xAA. It then reads three header bytes, then `len` bytes that it compares with the bytes it sent. On the first difference the transaction ends with `error` set and no 0x55 command is sent.
- R4: When every byte matches, the write issues a reset and the byte 0x55, then echoes the three captured header bytes unchanged and in the order they were received.
- R5: After the echo, the sequencer issues repeated line samples. The transaction ends without error on the first sample that reads low.
- R6: If the line stays high for `POLL_LIMIT` cycles of polling, the transaction ends with `error` set.
- R7: A start with `len` of zero, or with `len` larger than `BUF_DEPTH` (32), ends on the cycle after the start with `error` set. Such a start issues no engine operation.
- R8: `done` is high for exactly one cycle per accepted start, on success or on error. `error` rises only together with `done`, and it stays set until the next accepted start clears it.
- R9: After reset, `done`, `error` and `rd_valid` are low. The block then runs a write of the single byte 0x10 to address 0x201, using the R2 to R5 flow, without pulsing `done`.
- R10: A start that arrives while a transaction is running, including the power-up write, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, accepted only when idle |
| op_write | input | 1 | 1 = write transaction, 0 = read transaction |
| addr | input | 16 | Start address in slave memory |
| len | input | LEN_W | Byte count |
| wr_load | input | 1 | Store `wr_data` at the next buffer position |
| wr_data | input | 8 | Byte for the write buffer |
| rd_valid | output | 1 | One byte of read data is present |
| rd_data | output | 8 | Read data byte |
| done | output | 1 | One-cycle end-of-transaction pulse |
| error | output | 1 | Transaction failed; held until next start |
| eng_req | output | 1 | Engine operation request, held until acknowledged |
| eng_kind | output | 2 | Engine operation code |
| eng_wbyte | output | 8 | Byte to send for a write operation |
| eng_ack | input | 1 | Engine finished the requested operation |
| eng_rbyte | input | 8 | Byte read, or line level in bit 0 |

## Verification
The slave is modelled at byte level. The model honours an address and commits data only when it receives the exact command sequence, so a wrong order or a wrong byte shows up as bad read data or unchanged memory. Several kinds of transaction are tried: writes of 1, 4 and 32 bytes, and reads at the same places and at untouched memory. Together these separate the address byte order, the data byte order and the handling of buffer limits. Three faults are injected: a corrupted read-back byte, a slave that stays busy, and a start during a transfer. These separate an abort before the copy, the poll timeout, and start filtering. Zero and oversized lengths check that a request is refused without any traffic to the engine.

// File: rtl/scr_seq_pkg.sv
package scr_seq_pkg;

   typedef enum logic [1:0] {
      K_RESET  = 2'd0,
      K_WRITE  = 2'd1,
      K_READ   = 2'd2,
      K_SAMPLE = 2'd3
   } eng_kind_t;

   typedef enum logic [1:0] {
      PH_RDMEM,
      PH_WRSP,
      PH_RDSP,
      PH_CPSP
   } phase_t;

   typedef enum logic [3:0] {
      S_IDLE, S_RST, S_CMD, S_ALO, S_AHI, S_DATA,
      S_HDR, S_CMP, S_ECHO, S_POLL, S_FIN
   } st_t;

   localparam logic [7:0] CMD_RDMEM = 8'hF0;
   localparam logic [7:0] CMD_WRSP  = 8'h0F;
   localparam logic [7:0] CMD_RDSP  = 8'hAA;
   localparam logic [7:0] CMD_CPSP  = 8'h55;

   function automatic logic [7:0] cmd_of(phase_t ph);
      case (ph)
         PH_RDMEM: return CMD_RDMEM;
         PH_WRSP:  return CMD_WRSP;
         PH_RDSP:  return CMD_RDSP;
         default:  return CMD_CPSP;
      endcase
   endfunction

endpackage

// File: rtl/scr_seq_wrbuf.sv
module scr_seq_wrbuf #(
   parameter int DEPTH = 32,
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [7:0]       load_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [7:0]       rd_byte
);
   localparam logic [IDX_W:0] FULL = (IDX_W+1)'(DEPTH);

   logic [7:0]     store [DEPTH];
   logic [IDX_W:0] ptr;

   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         ptr <= '0;
      else if (load && ptr < FULL)
         ptr <= ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (load && !clr && ptr < FULL)
         store[ptr[IDX_W-1:0]] <= load_data;
   end

   assign rd_byte = store[rd_idx];

   AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= FULL); // R2

endmodule

// File: rtl/scr_seq_timer.sv
module scr_seq_timer #(
   parameter int LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   generate
      if (LIMIT == 0) begin : g_none
         assign expired = 1'b0;
      end else begin : g_count
         localparam int CW = $clog2(LIMIT + 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n || !run)
               cnt <= '0;
            else if (cnt != CW'(LIMIT - 1))
               cnt <= cnt + 1'b1;
         end
         assign expired = run && (cnt == CW'(LIMIT - 1));
      end
   endgenerate

endmodule

// File: rtl/scr_seq_top.sv
module scr_seq_top
   import scr_seq_pkg::*;
#(
   parameter int          BUF_DEPTH  = 32,
   parameter int          LEN_W      = 6,
   parameter int          POLL_LIMIT = 1000,
   parameter logic [15:0] CTRL_ADDR  = 16'h0201,
   parameter logic [7:0]  OSC_ON     = 8'h10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             op_write,
   input  logic [15:0]      addr,
   input  logic [LEN_W-1:0] len,
   input  logic             wr_load,
   input  logic [7:0]       wr_data,
   output logic             rd_valid,
   output logic [7:0]       rd_data,
   output logic             done,
   output logic             error,
   output logic             eng_req,
   output logic [1:0]       eng_kind,
   output logic [7:0]       eng_wbyte,
   input  logic             eng_ack,
   input  logic [7:0]       eng_rbyte
);
   localparam int IDX_W = $clog2(BUF_DEPTH);
   localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(BUF_DEPTH);
   localparam logic [LEN_W-1:0] HDR_END = LEN_W'(2);

   generate
      if (BUF_DEPTH < 2) begin : g_bad_depth
         $error("BUF_DEPTH must be at least 2");
      end
      if (LEN_W < $clog2(BUF_DEPTH + 1)) begin : g_bad_len
         $error("LEN_W too narrow for BUF_DEPTH");
      end
      if (LEN_W < 2) begin : g_bad_len2
         $error("LEN_W must be at least 2");
      end
   endgenerate

   st_t              state;
   phase_t           phase;
   logic             init_q;
   logic             err_q;
   logic [LEN_W-1:0] idx;
   logic [LEN_W-1:0] len_q;
   logic [15:0]      addr_q;
   logic [7:0]       hdr [3];
   logic             rdv_q;
   logic [7:0]       rdd_q;
   logic [7:0]       buf_byte;
   logic [7:0]       cur_byte;
   logic             last;
   logic             poll_expired;
   logic             accept;
   logic             bad_len;

   assign accept   = (state == S_IDLE) && start;
   assign bad_len  = (len == '0) || (len > MAX_LEN);
   assign cur_byte = init_q ? OSC_ON : buf_byte;
   assign last     = (idx == len_q - LEN_W'(1));

   scr_seq_wrbuf #(.DEPTH(BUF_DEPTH), .IDX_W(IDX_W)) wrbuf_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (accept),
      .load      (wr_load),
      .load_data (wr_data),
      .rd_idx    (idx[IDX_W-1:0]),
      .rd_byte   (buf_byte)
   );

   scr_seq_timer #(.LIMIT(POLL_LIMIT)) timer_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state == S_POLL),
      .expired (poll_expired)
   );

   always_comb begin
      eng_req   = 1'b1;
      eng_kind  = K_WRITE;
      eng_wbyte = 8'h00;
      case (state)
         S_RST:  eng_kind = K_RESET;
         S_CMD:  eng_wbyte = cmd_of(phase);
         S_ALO:  eng_wbyte = addr_q[7:0];
         S_AHI:  eng_wbyte = addr_q[15:8];
         S_DATA: begin
            if (phase == PH_RDMEM) eng_kind = K_READ;
            else                   eng_wbyte = cur_byte;
         end
         S_HDR, S_CMP: eng_kind = K_READ;
         S_ECHO: eng_wbyte = hdr[idx[1:0]];
         S_POLL: eng_kind = K_SAMPLE;
         default: eng_req = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= S_RST;
         phase  <= PH_WRSP;
         init_q <= 1'b1;
         err_q  <= 1'b0;
         idx    <= '0;
         len_q  <= LEN_W'(1);
         addr_q <= CTRL_ADDR;
         rdv_q  <= 1'b0;
         rdd_q  <= 8'h00;
         for (int i = 0; i < 3; i++) hdr[i] <= 8'h00;
      end else begin
         rdv_q <= 1'b0;
         case (state)
            S_IDLE: if (start) begin
               err_q  <= bad_len;
               idx    <= '0;
               addr_q <= addr;
               len_q  <= len;
               init_q <= 1'b0;
               phase  <= op_write ? PH_WRSP : PH_RDMEM;
               state  <= bad_len ? S_FIN : S_RST;
            end
            S_RST: if (eng_ack) state <= S_CMD;
            S_CMD: if (eng_ack) begin
               idx <= '0;
               case (phase)
                  PH_CPSP: state <= S_ECHO;
                  PH_RDSP: state <= S_HDR;
                  default: state <= S_ALO;
               endcase
            end
            S_ALO: if (eng_ack) state <= S_AHI;
            S_AHI: if (eng_ack) state <= S_DATA;
            S_DATA: if (eng_ack) begin
               if (phase == PH_RDMEM) begin
                  rdv_q <= 1'b1;
                  rdd_q <= eng_rbyte;
               end
               idx <= idx + 1'b1;
               if (last) begin
                  idx <= '0;
                  if (phase == PH_RDMEM) begin
                     state <= S_FIN;
                  end else begin
                     phase <= PH_RDSP;
                     state <= S_RST;
                  end
               end
            end
            S_HDR: if (eng_ack) begin
               hdr[idx[1:0]] <= eng_rbyte;
               idx <= idx + 1'b1;
               if (idx == HDR_END) begin
                  idx   <= '0;
                  state <= S_CMP;
               end
            end
            S_CMP: if (eng_ack) begin
               if (eng_rbyte != cur_byte) begin
                  err_q <= 1'b1;
                  state <= S_FIN;
               end else if (last) begin
                  idx   <= '0;
                  phase <= PH_CPSP;
                  state <= S_RST;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            S_ECHO: if (eng_ack) begin
               idx <= idx + 1'b1;
               if (idx == HDR_END) state <= S_POLL;
            end
            S_POLL: begin
               if (eng_ack && !eng_rbyte[0]) begin
                  state <= S_FIN;
               end else if (poll_expired) begin
                  err_q <= 1'b1;
                  state <= S_FIN;
               end
            end
            S_FIN:   state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign done     = (state == S_FIN) && !init_q;
   assign error    = err_q && !init_q;
   assign rd_valid = rdv_q;
   assign rd_data  = rdd_q;

   AST_RDV_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ($past(eng_ack) && $past(eng_kind) == K_READ)); // R1
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && !eng_ack && eng_kind != K_SAMPLE)
      |=> (eng_req && $stable(eng_kind) && $stable(eng_wbyte))); // R2
   AST_POLL_LOW_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && eng_ack && eng_kind == K_SAMPLE && !eng_rbyte[0] && !init_q)
      |=> (done && !error)); // R5
   AST_BAD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && bad_len) |=> (done && error && !eng_req)); // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(error) |-> done); // R8
   AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(error) |-> $past(start)); // R8

endmodule

// File: tb/scr_seq_top_tb_top.sv
`timescale 1ns/1ps
module scr_seq_top_tb_top;

   localparam int PLIM  = 200;
   localparam int LEN_W = 6;

   typedef struct packed {
      bit        wr;
      bit [15:0] a;
      bit [7:0]  n;
      bit [7:0]  seed;
      bit        err;
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{1'b1, 16'h0203, 8'd4,  8'h11, 1'b0},
      '{1'b0, 16'h0203, 8'd4,  8'h00, 1'b0},
      '{1'b1, 16'h0040, 8'd32, 8'h3C, 1'b0},
      '{1'b0, 16'h0040, 8'd32, 8'h00, 1'b0},
      '{1'b0, 16'h0100, 8'd1,  8'h00, 1'b0},
      '{1'b1, 16'h00FF, 8'd1,  8'hA5, 1'b0},
      '{1'b1, 16'h0010, 8'd0,  8'h00, 1'b1},
      '{1'b0, 16'h0010, 8'd33, 8'h00, 1'b1}
   };

   logic clk = 0;
   logic rst_n = 0;
   logic start = 0, op_write = 0, wr_load = 0;
   logic [15:0] addr = 0;
   logic [LEN_W-1:0] len = 0;
   logic [7:0] wr_data = 0;
   logic rd_valid, done, error, eng_req;
   logic [7:0] rd_data, eng_wbyte;
   logic [1:0] eng_kind;
   logic eng_ack = 0;
   logic [7:0] eng_rbyte = 0;

   always #2 clk = ~clk;

   scr_seq_top #(.LEN_W(LEN_W), .POLL_LIMIT(PLIM)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .op_write(op_write),
      .addr(addr), .len(len), .wr_load(wr_load), .wr_data(wr_data),
      .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .error(error),
      .eng_req(eng_req), .eng_kind(eng_kind), .eng_wbyte(eng_wbyte),
      .eng_ack(eng_ack), .eng_rbyte(eng_rbyte)
   );

   int n_chk = 0, n_bad = 0;
   logic [7:0] mem [1024];
   logic [7:0] exp_mem [1024];
   logic [7:0] scr [64];
   logic [7:0] rd_buf [64];
   int rd_n = 0, done_n = 0, reqs = 0, samples = 0, copies = 0;
   int sl_cmd = -1, sl_cnt = 0, scr_n = 0, busy = 0;
   logic [15:0] sl_ta = 0, sl_ra = 0;
   logic [7:0] sl_es = 0;
   logic [7:0] echo [3];
   bit corrupt = 0, stuck = 0, echo_bad = 0;

   task automatic chk(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(logic [7:0] seed, int i);
      return seed + 8'(i * 29) ^ 8'(i);
   endfunction

   task automatic serve();
      reqs++;
      case (eng_kind)
         2'd0: begin sl_cmd = -1; sl_cnt = 0; end
         2'd1: begin
            if (sl_cmd < 0) begin
               sl_cmd = int'(eng_wbyte); sl_cnt = 0;
            end else begin
               if (sl_cmd == 'hF0) begin
                  if (sl_cnt == 0) sl_ra[7:0] = eng_wbyte;
                  if (sl_cnt == 1) sl_ra[15:8] = eng_wbyte;
               end else if (sl_cmd == 'h0F) begin
                  if (sl_cnt == 0) sl_ta[7:0] = eng_wbyte;
                  else if (sl_cnt == 1) sl_ta[15:8] = eng_wbyte;
                  else begin
                     scr[(sl_cnt-2) % 64] = eng_wbyte;
                     scr_n = sl_cnt - 1;
                     sl_es = 8'(scr_n) | 8'hA0;
                  end
               end else if (sl_cmd == 'h55 && sl_cnt < 3) begin
                  echo[sl_cnt] = eng_wbyte;
                  if (sl_cnt == 2) begin
                     if (echo[0] == sl_ta[7:0] && echo[1] == sl_ta[15:8] && echo[2] == sl_es) begin
                        copies++;
                        for (int i = 0; i < scr_n; i++) mem[(int'(sl_ta) + i) % 1024] = scr[i];
                        busy = stuck ? 1000000 : 3;
                     end else echo_bad = 1;
                  end
               end
               sl_cnt++;
            end
         end
         2'd2: begin
            if (sl_cmd == 'hF0) begin
               eng_rbyte = mem[int'(sl_ra) % 1024];
               sl_ra++;
            end else if (sl_cmd == 'hAA) begin
               if (sl_cnt == 0) eng_rbyte = sl_ta[7:0];
               else if (sl_cnt == 1) eng_rbyte = sl_ta[15:8];
               else if (sl_cnt == 2) eng_rbyte = sl_es;
               else eng_rbyte = scr[(sl_cnt-3) % 64] ^ ((corrupt && sl_cnt == 4) ? 8'h01 : 8'h00);
               sl_cnt++;
            end else eng_rbyte = 8'hFF;
         end
         default: begin
            samples++;
            eng_rbyte = (busy > 0) ? 8'h01 : 8'h00;
            if (busy > 0) busy--;
         end
      endcase
   endtask

   initial begin
      forever begin
         @(negedge clk);
         if (eng_ack) eng_ack = 0;
         else if (eng_req && rst_n) begin serve(); eng_ack = 1; end
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && done) done_n++;
         if (rst_n && rd_valid) begin
            rd_buf[rd_n % 64] = rd_data;
            rd_n++;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   int cyc;
   task automatic run(bit wr, logic [15:0] a, int n, logic [7:0] seed, bit extra);
      rd_n = 0; done_n = 0; reqs = 0; samples = 0;
      for (int i = 0; i < n && i < 40; i++) begin
         @(negedge clk);
         wr_load = 1; wr_data = pat(seed, i);
      end
      @(negedge clk);
      wr_load = 0;
      op_write = wr; addr = a; len = LEN_W'(n); start = 1;
      @(negedge clk);
      start = 0;
      cyc = 0;
      while (!done && cyc < 5000) begin
         start = (extra && cyc == 10);
         @(negedge clk);
         cyc++;
      end
      start = 0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) begin
         mem[i] = 8'(i) ^ 8'h5A;
         exp_mem[i] = 8'(i) ^ 8'h5A;
      end
      repeat (4) @(negedge clk);
      chk(done == 0 && error == 0 && rd_valid == 0, "R9 reset outputs", {done, error, rd_valid}, 0);
      rst_n = 1;
      @(negedge clk);
      start = 1; op_write = 0; addr = 16'h0100; len = 1;   // ignored during power-up write
      @(negedge clk);
      start = 0;
      repeat (400) @(negedge clk);
      chk(mem[16'h0201] == 8'h10, "R9 oscillator enable", mem[16'h0201], 8'h10);
      chk(copies == 1, "R9 power-up copy", copies, 1);
      chk(done_n == 0 && rd_n == 0, "R9/R10 no done during power-up", done_n, 0);
      exp_mem[16'h0201] = 8'h10;

      for (int v = 0; v < 8; v++) begin
         automatic int c0 = copies;
         run(VEC[v].wr, VEC[v].a, int'(VEC[v].n), VEC[v].seed, 0);
         chk(done_n == 1, "R8 single done", done_n, 1);
         chk(error == VEC[v].err, "R8 error flag", error, VEC[v].err);
         if (VEC[v].err) begin
            chk(reqs == 0 && cyc <= 2, "R7 immediate reject", reqs, 0);
         end else if (VEC[v].wr) begin
            for (int i = 0; i < int'(VEC[v].n); i++) exp_mem[int'(VEC[v].a) + i] = pat(VEC[v].seed, i);
            for (int i = 0; i < int'(VEC[v].n); i++)
               chk(mem[int'(VEC[v].a) + i] == exp_mem[int'(VEC[v].a) + i], "R2 staged data",
                   mem[int'(VEC[v].a) + i], exp_mem[int'(VEC[v].a) + i]);
            chk(copies == c0 + 1 && !echo_bad, "R4 copy echo", copies - c0, 1);
            chk(samples == 4, "R5 poll until low", samples, 4);
         end else begin
            chk(rd_n == int'(VEC[v].n), "R1 read count", rd_n, VEC[v].n);
            for (int i = 0; i < int'(VEC[v].n); i++)
               chk(rd_buf[i] == exp_mem[int'(VEC[v].a) + i], "R1 read data",
                   rd_buf[i], exp_mem[int'(VEC[v].a) + i]);
         end
      end

      // R3: read-back mismatch aborts before copy
      begin
         automatic int c0 = copies;
         corrupt = 1;
         run(1, 16'h0080, 3, 8'h77, 0);
         corrupt = 0;
         chk(error == 1 && done_n == 1, "R3 mismatch error", error, 1);
         chk(copies == c0 && samples == 0, "R3 no copy issued", copies - c0, 0);
         chk(mem[16'h0081] == exp_mem[16'h0081], "R3 memory untouched", mem[16'h0081], exp_mem[16'h0081]);
      end

      // R6: slave stays busy
      stuck = 1;
      run(1, 16'h0090, 2, 8'h21, 0);
      stuck = 0; busy = 0;
      chk(error == 1 && done_n == 1, "R6 timeout error", error, 1);
      chk(cyc >= PLIM, "R6 timeout length", cyc, PLIM);
      for (int i = 0; i < 2; i++) exp_mem[16'h0090 + i] = pat(8'h21, i);

      // R8 + R10: error cleared by next start; extra start mid-transfer ignored
      run(0, 16'h0090, 8, 8'h00, 1);
      chk(error == 0, "R8 error cleared", error, 0);
      chk(done_n == 1, "R10 extra start ignored", done_n, 1);
      chk(rd_n == 8, "R10 read count", rd_n, 8);
      chk(rd_buf[0] == exp_mem[16'h0090] && rd_buf[7] == exp_mem[16'h0097], "R1 read after timeout",
          rd_buf[7], exp_mem[16'h0097]);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule